// File: doc/BRIEF.md
# Serial Adapter Register and Interrupt Block

This block is the processor-facing half of a byte-oriented asynchronous serial adapter. A two-location bus port gives access to four registers. Location 0 takes a control byte on writes and returns a status byte on reads. Location 1 loads the transmit holding byte on writes and returns the receive holding byte on reads.

The serial side is a pair of byte-wide handshakes. The receiver offers a byte with a one-cycle valid strobe. The transmitter sees a pending byte and pulses a take strobe when its shifter has accepted that byte. A debug qualifier on bus reads makes them side-effect-free, so a monitor can inspect the block without disturbing it.

A single registered, active-high interrupt line signals received data and emptied transmit buffers, each under its own enable. A non-debug read of the status location acknowledges the interrupt.

Top module: `serial_regblock`

## Requirements
- R1: After synchronous reset the status byte reads 0x02 (transmit empty set, all other flags clear), `irq` is 0 and `tx_pending` is 0.
- R2: Reading location 0 returns status with bit 0 = receive full, bit 1 = transmit empty, bit 5 = overrun, bit 7 = interrupt request, and all other bits 0. Reading location 1 returns the most recently received byte. `rd_data` is 0 when no read is addressed.
- R3: Writing location 1 loads the transmit byte. From the next cycle, `tx_pending` is 1, `tx_byte` carries the written value and status bit 1 is 0. The write by itself never raises `irq`.
- R4: A `tx_take` pulse while `tx_pending` is 1 sets transmit empty on the next edge. If control bits 6:5 equal 01, `irq` is also raised on that edge. Any other value of those bits (for example control 0x00 or 0x02) leaves `irq` unchanged.
- R5: A `rx_valid` pulse into an empty receive buffer sets receive full on the next edge. It also raises `irq` on that edge when control bit 7 is 1, and leaves `irq` unchanged when that bit is 0.
- R6: A `rx_valid` pulse while receive full is set, with no consuming data read in the same cycle, sets overrun. The newer byte replaces the held byte.
- R7: A non-debug read of location 1 clears receive full and overrun on the next edge. If a byte arrives in the same cycle, receive full stays set, overrun stays clear, and the arrival counts as landing in an empty buffer.
- R8: A read with `bus_peek` = 1, at either location, changes no flag and does not acknowledge `irq`.
- R9: A non-debug read of location 0 clears `irq` on the next edge, unless an enabled interrupt event occurs in the same cycle; that event wins.
- R10: Writing control with bits 1:0 = 11 is a master reset. On the next edge receive full, overrun and `irq` clear, transmit empty sets, and `tx_pending` drops, whatever else occurs in that cycle.
- R11: Interrupt enables take effect from the edge on which the control write lands. Events in the same cycle as that write use the previous enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Register location, 0 or 1 |
| bus_wdata | input | DATA_W | Write data |
| bus_peek | input | 1 | Read has no side effects |
| rd_data | output | DATA_W | Read data, combinational from state and address |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DATA_W | Received byte |
| tx_pending | output | 1 | Transmit byte waiting for the shifter |
| tx_byte | output | DATA_W | Transmit byte |
| tx_take | input | 1 | Shifter accepted the pending byte |
| irq | output | 1 | Interrupt request, registered, active high |

## Verification
Every flag, `tx_pending`, `tx_byte` and `irq` moves on the first rising edge after the cycle that carries the write, read, strobe or take, so it is visible one cycle after its stimulus. `rd_data` is combinational over that registered state and the present address. The bench drives inputs just after each rising edge. It advances a behavioural model on the same edge and compares all outputs at the following falling edge, which is exactly where each result is first due. Directed phases for each requirement are followed by random traffic that hits same-cycle collisions of reads, arrivals, takes and master resets.

// File: rtl/serial_regblock_pkg.sv
// Package: shared bit positions and control decode type for the serial
// register block. Assumes an 8-bit or wider data path.
package serial_regblock_pkg;
    localparam int ST_RXFULL  = 0;
    localparam int ST_TXEMPTY = 1;
    localparam int ST_OVERRUN = 5;
    localparam int ST_IRQ     = 7;
    localparam int CT_RXIE    = 7;
    localparam int CT_TXHI    = 6;
    localparam int CT_TXLO    = 5;

    typedef struct packed {
        logic rx_ie;
        logic tx_ie;
    } irq_en_t;
endpackage

// File: rtl/serial_regblock_ctrl.sv
// Control register: stores the control byte, decodes interrupt enables
// and flags a master-reset write. Assumes DATA_W >= 8.
module serial_regblock_ctrl
    import serial_regblock_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output irq_en_t           en,
    output logic              mreset
);
    logic [DATA_W-1:0] ctrl_q;

    // Holds the last written control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl_q <= '0;
        else if (wr_en) ctrl_q <= wdata;
    end

    // Decodes enables from the stored byte and master reset from the write.
    always_comb begin
        en.rx_ie = ctrl_q[CT_RXIE];
        en.tx_ie = (ctrl_q[CT_TXHI:CT_TXLO] == 2'b01);
        mreset   = wr_en && (wdata[1:0] == 2'b11);
    end
endmodule

// File: rtl/serial_regblock_rx.sv
// Receive holding: one-byte buffer with full and overrun flags. A consuming
// read and an arrival in the same cycle count as an arrival into an empty
// buffer. Assumes rx_valid is a one-cycle strobe.
module serial_regblock_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              consume,
    input  logic              mreset,
    output logic [DATA_W-1:0] buf_q,
    output logic              full_q,
    output logic              ovr_q,
    output logic              fresh
);
    logic ovr_set;

    // Classifies an arrival as landing fresh or overrunning.
    always_comb begin
        fresh   = rx_valid && (!full_q || consume);
        ovr_set = rx_valid && full_q && !consume;
    end

    // Captures every arriving byte, newest wins.
    always_ff @(posedge clk) begin
        if (!rst_n)        buf_q <= '0;
        else if (rx_valid) buf_q <= rx_byte;
    end

    // Tracks full and overrun; master reset dominates.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset) begin
            full_q <= 1'b0;
            ovr_q  <= 1'b0;
        end else begin
            full_q <= rx_valid || (full_q && !consume);
            ovr_q  <= ovr_set || (ovr_q && !consume);
        end
    end
endmodule

// File: rtl/serial_regblock_tx.sv
// Transmit holding: one-byte buffer loaded by the bus and drained by the
// shifter's take strobe. A load in the take cycle keeps the buffer full.
module serial_regblock_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              take,
    input  logic              mreset,
    output logic [DATA_W-1:0] buf_q,
    output logic              empty_q,
    output logic              drained
);
    // Flags a take that actually removes a byte.
    always_comb drained = take && !empty_q;

    // Holds the byte offered to the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n)    buf_q <= '0;
        else if (load) buf_q <= wdata;
    end

    // Tracks emptiness; master reset dominates, then load, then take.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset) empty_q <= 1'b1;
        else if (load)        empty_q <= 1'b0;
        else if (take)        empty_q <= 1'b1;
    end
endmodule

// File: rtl/serial_regblock_irq.sv
// Interrupt latch: set by enabled events, cleared by a status
// acknowledge; master reset clears it and set beats acknowledge.
module serial_regblock_irq
    import serial_regblock_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  irq_en_t en,
    input  logic    rx_fresh,
    input  logic    tx_drained,
    input  logic    ack,
    input  logic    mreset,
    output logic    irq_q
);
    logic raise;

    // Combines the enabled interrupt sources.
    always_comb raise = (en.rx_ie && rx_fresh) || (en.tx_ie && tx_drained);

    // Updates the registered request line.
    always_ff @(posedge clk) begin
        if (!rst_n || mreset) irq_q <= 1'b0;
        else if (raise)       irq_q <= 1'b1;
        else if (ack)         irq_q <= 1'b0;
    end
endmodule

// File: rtl/serial_regblock.sv
// Top: bus decode, status assembly and read mux for the serial adapter
// register block. Assumes one bus access per cycle and DATA_W >= 8.
module serial_regblock
    import serial_regblock_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_peek,
    output logic [DATA_W-1:0] rd_data,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              tx_pending,
    output logic [DATA_W-1:0] tx_byte,
    input  logic              tx_take,
    output logic              irq
);
    logic              wr_ctrl, wr_data, rd_any, rd_stat_fx, rd_data_fx;
    logic              mreset, rx_fresh, tx_drained;
    logic              rx_full, rx_ovr, tx_empty;
    logic [DATA_W-1:0] rx_buf, status;
    irq_en_t           en;

    // Splits bus cycles into register actions.
    always_comb begin
        wr_ctrl    = bus_sel &&  bus_wr && !bus_addr;
        wr_data    = bus_sel &&  bus_wr &&  bus_addr;
        rd_any     = bus_sel && !bus_wr;
        rd_stat_fx = rd_any && !bus_addr && !bus_peek;
        rd_data_fx = rd_any &&  bus_addr && !bus_peek;
    end

    serial_regblock_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(bus_wdata),
        .en(en), .mreset(mreset)
    );

    serial_regblock_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .consume(rd_data_fx), .mreset(mreset), .buf_q(rx_buf),
        .full_q(rx_full), .ovr_q(rx_ovr), .fresh(rx_fresh)
    );

    serial_regblock_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(wr_data), .wdata(bus_wdata),
        .take(tx_take), .mreset(mreset), .buf_q(tx_byte),
        .empty_q(tx_empty), .drained(tx_drained)
    );

    serial_regblock_irq u_irq (
        .clk(clk), .rst_n(rst_n), .en(en), .rx_fresh(rx_fresh),
        .tx_drained(tx_drained), .ack(rd_stat_fx), .mreset(mreset),
        .irq_q(irq)
    );

    // Assembles the status byte from the flags.
    always_comb begin
        status             = '0;
        status[ST_RXFULL]  = rx_full;
        status[ST_TXEMPTY] = tx_empty;
        status[ST_OVERRUN] = rx_ovr;
        status[ST_IRQ]     = irq;
    end

    // Selects read data for the addressed location.
    always_comb begin
        if (!rd_any)       rd_data = '0;
        else if (bus_addr) rd_data = rx_buf;
        else               rd_data = status;
    end

    assign tx_pending = !tx_empty;
endmodule

// File: rtl/serial_regblock_chk.sv
// Checker: temporal properties on the ports of serial_regblock, bound below.
module serial_regblock_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_peek,
    input logic [DATA_W-1:0] rd_data,
    input logic              rx_valid,
    input logic [DATA_W-1:0] rx_byte,
    input logic              tx_pending,
    input logic [DATA_W-1:0] tx_byte,
    input logic              tx_take,
    input logic              irq
);
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !tx_pending));

    p_irq_mirror_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !bus_addr) |-> (rd_data[7] == irq));

    p_tx_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr) |=>
            (tx_pending && tx_byte == $past(bus_wdata)));

    p_tx_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr && !irq && !tx_take && !rx_valid) |=> !irq);

    p_tx_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pending && tx_take && !(bus_sel && bus_wr && bus_addr)) |=> !tx_pending);

    p_peek_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_peek && !rx_valid && !tx_take) |=> $stable(irq));

    p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !bus_addr && !bus_peek && !rx_valid && !tx_take) |=> !irq);

    p_master_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_addr && bus_wdata[1:0] == 2'b11) |=>
            (!irq && !tx_pending));
endmodule

bind serial_regblock serial_regblock_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_serial_regblock.sv
module sim_serial_regblock;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 0, bus_wr = 0, bus_addr = 0, bus_peek = 0;
    logic [DW-1:0] bus_wdata = '0, rx_byte = '0;
    logic          rx_valid = 0, tx_take = 0;
    logic [DW-1:0] rd_data, tx_byte;
    logic          tx_pending, irq;

    int    n_cmp = 0, n_bad = 0;
    string tag = "R1";
    bit    done = 0;

    // behavioural reference state
    byte unsigned rxq[$];
    byte unsigned txq[$];
    int  m_ctrl = 0, m_last_rx = 0, m_txb = 0;
    bit  m_ovr = 0, m_irq = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_regblock #(.DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_peek(bus_peek),
        .rd_data(rd_data), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_pending(tx_pending), .tx_byte(tx_byte), .tx_take(tx_take),
        .irq(irq)
    );

    // reference model advance on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_ctrl = 0; m_last_rx = 0; m_txb = 0; m_ovr = 0; m_irq = 0;
        end else begin
            bit mr, eat, ack, fresh, ovs, drain, rx_en, tx_en;
            mr    = bus_sel && bus_wr && !bus_addr && (bus_wdata % 4 == 3);
            eat   = bus_sel && !bus_wr && bus_addr && !bus_peek;
            ack   = bus_sel && !bus_wr && !bus_addr && !bus_peek;
            fresh = rx_valid && (rxq.size() == 0 || eat);
            ovs   = rx_valid && rxq.size() > 0 && !eat;
            drain = tx_take && txq.size() > 0;
            rx_en = (m_ctrl / 128) % 2 == 1;
            tx_en = (m_ctrl / 32) % 4 == 1;
            if (mr) m_irq = 0;
            else if ((rx_en && fresh) || (tx_en && drain)) m_irq = 1;
            else if (ack) m_irq = 0;
            if (rx_valid) m_last_rx = rx_byte;
            if (mr) begin rxq.delete(); m_ovr = 0; end
            else begin
                if (eat) begin rxq.delete(); m_ovr = 0; end
                if (rx_valid) begin rxq.delete(); rxq.push_back(rx_byte); end
                if (ovs) m_ovr = 1;
            end
            if (mr) txq.delete();
            else if (bus_sel && bus_wr && bus_addr) begin
                txq.delete(); txq.push_back(bus_wdata); m_txb = bus_wdata;
            end else if (drain) txq.delete();
            if (bus_sel && bus_wr && !bus_addr) m_ctrl = bus_wdata;
        end
    end

    function automatic int exp_rd();
        int s;
        if (!(bus_sel && !bus_wr)) return 0;
        if (bus_addr) return m_last_rx;
        s = (rxq.size() > 0 ? 1 : 0) + (txq.size() == 0 ? 2 : 0)
          + (m_ovr ? 32 : 0) + (m_irq ? 128 : 0);
        return s;
    endfunction

    task automatic cmp(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // compare against the model at every falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("irq", irq, m_irq);
            cmp("tx_pending", tx_pending, txq.size() > 0);
            if (tx_pending) cmp("tx_byte", tx_byte, m_txb);
            cmp("rd_data", rd_data, exp_rd());
        end
    end

    task automatic step(bit s, bit w, bit a, int d, bit pk, bit rv, int rb, bit tk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d[DW-1:0]; bus_peek = pk;
        rx_valid = rv; rx_byte = rb[DW-1:0]; tx_take = tk;
        @(posedge clk); #1;
    endtask
    task automatic idle();                 step(0,0,0,0,0,0,0,0); endtask
    task automatic wctl(int d);            step(1,1,0,d,0,0,0,0); endtask
    task automatic wdat(int d);            step(1,1,1,d,0,0,0,0); endtask
    task automatic rstat(bit pk);          step(1,0,0,0,pk,0,0,0); endtask
    task automatic rdat(bit pk);           step(1,0,1,0,pk,0,0,0); endtask
    task automatic rxin(int b);            step(0,0,0,0,0,1,b,0); endtask
    task automatic take();                 step(0,0,0,0,0,0,0,1); endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1; n_bad++; n_cmp++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        tag = "R1"; rstat(1); rstat(0); idle();
        tag = "R2"; wctl(8'h00); rstat(0); rdat(1); rdat(0); idle();
        tag = "R3"; wctl(8'h20); wdat(8'h5A); idle(); rstat(1); idle();
        tag = "R4"; take(); idle(); rstat(1);
        tag = "R9"; rstat(0); idle();
        tag = "R4"; wctl(8'h02); wdat(8'hC3); take(); idle(); rstat(1);
        wctl(8'h00); wdat(8'h3C); take(); idle(); rstat(1);
        tag = "R5"; wctl(8'h80); rxin(8'h11); idle(); rdat(1); rstat(1);
        tag = "R9"; rstat(0); idle(); rdat(0);
        tag = "R5"; wctl(8'h00); rxin(8'h44); idle(); rstat(1);
        tag = "R6"; rxin(8'h22); idle(); rstat(1); rdat(1);
        tag = "R8"; rstat(1); rdat(1); rstat(1); idle();
        tag = "R7"; rdat(0); rstat(1); rxin(8'h55); rxin(8'h66);
        step(1,0,1,0,0,1,8'h77,0); rstat(1); rdat(0); rstat(1);
        tag = "R8"; wctl(8'h80); rxin(8'h12); rstat(1); rdat(1); rstat(1);
        tag = "R10"; wdat(8'h99); rxin(8'h34); wctl(8'h83); idle(); rstat(1);
        tag = "R11"; wctl(8'h80); step(1,1,0,8'h00,0,1,8'h21,0); rstat(0); rdat(0);
        step(1,1,0,8'h80,0,1,8'h22,0); rstat(1); rstat(0);
        tag = "RND";
        for (int i = 0; i < 3000; i++) begin
            int r, cv;
            r  = $urandom_range(0, 99);
            cv = $urandom_range(0, 255);
            if (r < 8 && cv % 4 == 3) cv = cv - 1;
            if (r == 0) cv = 8'hA3;
            step(r < 60, $urandom_range(0,1), $urandom_range(0,1), cv,
                 $urandom_range(0,3) == 0, $urandom_range(0,3) == 0,
                 $urandom_range(0,255), $urandom_range(0,2) == 0);
        end
        idle(); idle();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule